// File: doc/BRIEF.md
# Two-Block Flash Swap and Recovery Controller

This controller looks after a pair of flash blocks that together hold a persistent record store. Each block begins with a status word, and that word only ever has bits cleared. The controller writes the word through a fixed series of codes, so that after any power loss the pair of status words alone shows what was going on. When the append logic reports that the active block is full, the controller runs a swap. It marks the other block as the copy target and asks an external record enumerator to move the newest valid record of each ID. It then promotes the target, erases the old block, checks that every word of it reads back as all ones, and marks it verified.

At power-up the controller reads both status words and repairs whatever an interruption left behind. It erases any block in a bad state, picks the emptier block when both claim to be active, restarts a swap that was cut short during copying, and formats block 0 when neither block is active. While any of this work is running it holds `busy` and refuses append requests.

Top module: `fbs_swap_ctrl`

## Requirements
- R1: The status word sits at address 0 of a block. Its codes are erased 0xFFFF_FFFF, verified 0x00FF_FFFF, copy 0x0000_FFFF and active 0x0000_00FF. The controller programs nothing except verified, copy or active, and only at address 0.
- R2: Every erase is followed by a read of every word of that block. The verified code is programmed only when all of those words read 0xFFFF_FFFF.
- R3: A `swap_req` pulse while idle produces this sequence: program copy into the other block, pulse `copy_start` with `copy_src` = active block and `copy_dst` = other block, wait for `copy_done`, program active into the other block, erase the old block, blank-check it, and program verified into it. `active_blk` then names the other block.
- R4: At startup, a block whose status is neither verified nor active is erased, blank-checked and marked verified. When neither block is active, block 0 is repaired first.
- R5: If one block is active and the other holds the copy code, the copy block is repaired first and the swap is then run again from its start.
- R6: If both blocks hold the active code, both are scanned and the block with more all-ones words stays active. On a tie, block 0 stays active. The other block is erased, checked and marked verified.
- R7: When both blocks are verified and neither is active, active is programmed into block 0. `active_blk` becomes 0.
- R8: A failed blank check leads to exactly one more erase. If the check fails a second time, `fatal` is raised and stays high, no further flash command is issued, and `ready` drops.
- R9: While reset is applied, `ready`, `fatal` and `fl_req` are low. `busy` is high at every moment the controller is not idle. `append_grant` follows `append_req` only when idle.
- R10: Flash commands use a one-cycle `fl_req` pulse, with `fl_op` set to 0 for read, 1 for program and 2 for erase. No new command is issued until `fl_done` returns for the one in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| swap_req | input | 1 | Active block is full; start a swap |
| append_req | input | 1 | Append logic asks to add a record |
| append_grant | output | 1 | Append allowed this cycle |
| copy_start | output | 1 | One-cycle pulse: enumerator should copy records |
| copy_src | output | 1 | Block to copy records from |
| copy_dst | output | 1 | Block to copy records into |
| copy_done | input | 1 | Enumerator finished copying |
| fl_req | output | 1 | Flash command strobe |
| fl_op | output | 2 | 0 read, 1 program, 2 erase |
| fl_blk | output | 1 | Target block |
| fl_addr | output | $clog2(WORDS) | Word address within block |
| fl_wdata | output | 32 | Program data |
| fl_done | input | 1 | Command complete; read data valid |
| fl_rdata | input | 32 | Read data |
| active_blk | output | 1 | Block currently holding the live records |
| ready | output | 1 | An active block has been established |
| busy | output | 1 | Startup, repair or swap in progress |
| fatal | output | 1 | Block failed the blank check twice |

## Verification
The assertions assume that the flash answers each command with exactly one `fl_done`. They also assume that program operations only clear bits, that `copy_done` arrives once per `copy_start`, and that `swap_req` is raised only while the controller is idle. The bench models flash in exactly this way. It preloads status words and record fill before each reset, injects stuck words for a chosen number of erases, answers every copy handshake once, and raises swap requests only after `busy` has fallen.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
   localparam int unsigned SW = 32;
   localparam logic [SW-1:0] ST_ERASED   = 32'hFFFF_FFFF;
   localparam logic [SW-1:0] ST_VERIFIED = 32'h00FF_FFFF;
   localparam logic [SW-1:0] ST_COPY     = 32'h0000_FFFF;
   localparam logic [SW-1:0] ST_ACTIVE   = 32'h0000_00FF;
   localparam logic [1:0] OP_READ  = 2'd0;
   localparam logic [1:0] OP_PROG  = 2'd1;
   localparam logic [1:0] OP_ERASE = 2'd2;
   typedef enum logic [1:0] {DEC_READY, DEC_SCAN, DEC_REPAIR, DEC_FORMAT} decide_e;
endpackage

// File: rtl/fbs_status_eval.sv
module fbs_status_eval
   import fbs_pkg::*;
(
   input  logic [SW-1:0] st0,
   input  logic [SW-1:0] st1,
   output decide_e       dec,
   output logic          dblk,
   output logic          tgt_copy
);
   logic [1:0] is_act, is_ver, is_cpy;
   logic [SW-1:0] st [2];
   assign st[0] = st0;
   assign st[1] = st1;

   for (genvar b = 0; b < 2; b++) begin : g_cls
      assign is_act[b] = (st[b] == ST_ACTIVE);
      assign is_ver[b] = (st[b] == ST_VERIFIED);
      assign is_cpy[b] = (st[b] == ST_COPY);
   end

   always_comb begin
      dec      = DEC_FORMAT;
      dblk     = 1'b0;
      tgt_copy = 1'b0;
      if (&is_act) begin
         dec = DEC_SCAN;
      end else if (|is_act) begin
         if (is_ver[~is_act[1]]) begin
            dec  = DEC_READY;
            dblk = is_act[1];
         end else begin
            dec      = DEC_REPAIR;
            dblk     = ~is_act[1];
            tgt_copy = is_cpy[~is_act[1]];
         end
      end else if (!is_ver[0]) begin
         dec  = DEC_REPAIR;
         dblk = 1'b0;
      end else if (!is_ver[1]) begin
         dec  = DEC_REPAIR;
         dblk = 1'b1;
      end
   end
endmodule

// File: rtl/fbs_scan.sv
module fbs_scan
   import fbs_pkg::*;
#(
   parameter int unsigned WORDS = 16,
   localparam int unsigned AW   = $clog2(WORDS)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          blk,
   output logic          rd_req,
   output logic          rd_blk,
   output logic [AW-1:0] rd_addr,
   input  logic          rd_done,
   input  logic [SW-1:0] rd_data,
   output logic          done,
   output logic [AW:0]   ones_cnt,
   output logic          blank
);
   localparam logic [AW-1:0] LAST = AW'(WORDS - 1);
   localparam logic [AW:0]   FULL = (AW + 1)'(WORDS);

   logic run, pend, hit;
   logic [AW-1:0] idx;
   logic [AW:0]   cnt;

   assign hit      = (rd_data == ST_ERASED);
   assign rd_addr  = idx;
   assign ones_cnt = cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run <= 1'b0; pend <= 1'b0; idx <= '0; cnt <= '0;
         rd_req <= 1'b0; rd_blk <= 1'b0; done <= 1'b0; blank <= 1'b0;
      end else begin
         rd_req <= 1'b0;
         done   <= 1'b0;
         if (start) begin
            run <= 1'b1; pend <= 1'b0; idx <= '0; cnt <= '0;
            rd_blk <= blk; blank <= 1'b0;
         end else if (run) begin
            if (!pend) begin
               rd_req <= 1'b1;
               pend   <= 1'b1;
            end else if (rd_done) begin
               pend <= 1'b0;
               cnt  <= cnt + (AW + 1)'(hit);
               idx  <= idx + 1'b1;
               if (idx == LAST) begin
                  run   <= 1'b0;
                  done  <= 1'b1;
                  blank <= ((cnt + (AW + 1)'(hit)) == FULL);
               end
            end
         end
      end
   end

   // R10: the controller never restarts a scan that is still walking
   a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !run);
   // R10: one read in flight at a time
   a_r10_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> !rd_req);
endmodule

// File: rtl/fbs_swap_ctrl.sv
module fbs_swap_ctrl
   import fbs_pkg::*;
#(
   parameter int unsigned WORDS = 16,
   localparam int unsigned AW   = $clog2(WORDS)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          swap_req,
   input  logic          append_req,
   output logic          append_grant,
   output logic          copy_start,
   output logic          copy_src,
   output logic          copy_dst,
   input  logic          copy_done,
   output logic          fl_req,
   output logic [1:0]    fl_op,
   output logic          fl_blk,
   output logic [AW-1:0] fl_addr,
   output logic [SW-1:0] fl_wdata,
   input  logic          fl_done,
   input  logic [SW-1:0] fl_rdata,
   output logic          active_blk,
   output logic          ready,
   output logic          busy,
   output logic          fatal
);
   if (WORDS < 4 || (WORDS & (WORDS - 1)) != 0) begin : g_chk
      $error("fbs_swap_ctrl: WORDS must be a power of two, at least 4");
   end

   typedef enum logic [3:0] {S_RD0, S_RD1, S_DEC, S_SCAN0, S_SCAN1, S_ERASE,
      S_VERIFY, S_PROG, S_IDLE, S_SWCOPY, S_SWACT, S_FATAL} state_e;

   state_e state, pnext;
   logic pend, tgt, act, restart, retried;
   logic c_req, c_blk;
   logic [1:0] c_op;
   logic [SW-1:0] st0, st1, pval;
   logic [AW:0] cnt0;

   logic scan_go, scan_blk, s_req, s_blk, s_done, s_blank;
   logic [AW-1:0] s_addr;
   logic [AW:0] s_cnt;
   decide_e dec;
   logic dblk, tgt_copy;

   fbs_status_eval u_eval (.st0(st0), .st1(st1), .dec(dec), .dblk(dblk), .tgt_copy(tgt_copy));

   fbs_scan #(.WORDS(WORDS)) u_scan (
      .clk(clk), .rst_n(rst_n), .start(scan_go), .blk(scan_blk),
      .rd_req(s_req), .rd_blk(s_blk), .rd_addr(s_addr), .rd_done(fl_done),
      .rd_data(fl_rdata), .done(s_done), .ones_cnt(s_cnt), .blank(s_blank));

   assign fl_req       = c_req | s_req;
   assign fl_op        = s_req ? OP_READ : c_op;
   assign fl_blk       = s_req ? s_blk : c_blk;
   assign fl_addr      = s_req ? s_addr : '0;
   assign fl_wdata     = pval;
   assign busy         = (state != S_IDLE);
   assign append_grant = append_req & (state == S_IDLE);
   assign active_blk   = act;
   assign copy_src     = act;
   assign copy_dst     = ~act;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= S_RD0; pnext <= S_RD0; pend <= 1'b0; tgt <= 1'b0; act <= 1'b0;
         restart <= 1'b0; retried <= 1'b0; c_req <= 1'b0; c_blk <= 1'b0; c_op <= OP_READ;
         st0 <= ST_ERASED; st1 <= ST_ERASED; pval <= ST_VERIFIED; cnt0 <= '0;
         scan_go <= 1'b0; scan_blk <= 1'b0; copy_start <= 1'b0; ready <= 1'b0; fatal <= 1'b0;
      end else begin
         c_req <= 1'b0; scan_go <= 1'b0; copy_start <= 1'b0;
         case (state)
            S_RD0, S_RD1: begin
               if (!pend) begin
                  c_req <= 1'b1; c_op <= OP_READ; c_blk <= (state == S_RD1); pend <= 1'b1;
               end else if (fl_done) begin
                  pend <= 1'b0;
                  if (state == S_RD0) begin st0 <= fl_rdata; state <= S_RD1; end
                  else begin st1 <= fl_rdata; state <= S_DEC; end
               end
            end
            S_DEC: begin
               case (dec)
                  DEC_READY: begin
                     act <= dblk; ready <= 1'b1;
                     if (restart) begin
                        restart <= 1'b0; tgt <= ~dblk; pval <= ST_COPY;
                        pnext <= S_SWCOPY; state <= S_PROG;
                     end else state <= S_IDLE;
                  end
                  DEC_SCAN: begin scan_go <= 1'b1; scan_blk <= 1'b0; state <= S_SCAN0; end
                  DEC_REPAIR: begin
                     tgt <= dblk; retried <= 1'b0; state <= S_ERASE;
                     if (tgt_copy) restart <= 1'b1;
                  end
                  default: begin tgt <= 1'b0; pval <= ST_ACTIVE; pnext <= S_RD0; state <= S_PROG; end
               endcase
            end
            S_SCAN0: if (s_done) begin
               cnt0 <= s_cnt; scan_go <= 1'b1; scan_blk <= 1'b1; state <= S_SCAN1;
            end
            S_SCAN1: if (s_done) begin
               tgt <= (s_cnt > cnt0) ? 1'b0 : 1'b1; retried <= 1'b0; state <= S_ERASE;
            end
            S_ERASE: begin
               if (!pend) begin
                  c_req <= 1'b1; c_op <= OP_ERASE; c_blk <= tgt; pend <= 1'b1;
               end else if (fl_done) begin
                  pend <= 1'b0; scan_go <= 1'b1; scan_blk <= tgt; state <= S_VERIFY;
               end
            end
            S_VERIFY: if (s_done) begin
               if (s_blank) begin pval <= ST_VERIFIED; pnext <= S_RD0; state <= S_PROG; end
               else if (!retried) begin retried <= 1'b1; state <= S_ERASE; end
               else begin fatal <= 1'b1; ready <= 1'b0; state <= S_FATAL; end
            end
            S_PROG: begin
               if (!pend) begin
                  c_req <= 1'b1; c_op <= OP_PROG; c_blk <= tgt; pend <= 1'b1;
               end else if (fl_done) begin
                  pend <= 1'b0; state <= pnext;
               end
            end
            S_IDLE: if (swap_req) begin
               tgt <= ~act; pval <= ST_COPY; pnext <= S_SWCOPY; state <= S_PROG;
            end
            S_SWCOPY: begin
               if (!pend) begin copy_start <= 1'b1; pend <= 1'b1; end
               else if (copy_done) begin
                  pend <= 1'b0; pval <= ST_ACTIVE; pnext <= S_SWACT; state <= S_PROG;
               end
            end
            S_SWACT: begin tgt <= act; retried <= 1'b0; state <= S_ERASE; end
            default: state <= S_FATAL;
         endcase
      end
   end

   // R1: only the three write-once codes ever reach the status word
   a_r1_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_req && fl_op == OP_PROG) |-> (fl_addr == '0 &&
       (fl_wdata == ST_VERIFIED || fl_wdata == ST_COPY || fl_wdata == ST_ACTIVE)));
   // R2: verified is written only after the scan saw a blank block
   a_r2_mark_after_blank: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_req && fl_op == OP_PROG && fl_wdata == ST_VERIFIED) |-> s_blank);
   // R9: the copy handshake only happens inside a busy swap
   a_r9_copy_busy: assert property (@(posedge clk) disable iff (!rst_n)
      copy_start |-> (busy && !append_grant));
   // R8: fatal holds and silences the flash port
   a_r8_fatal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      fatal |=> (fatal && !fl_req));
   // R10: each command strobe lasts one cycle
   a_r10_cmd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      fl_req |=> !fl_req);
endmodule

// File: tb/fbs_swap_ctrl_test.sv
`timescale 1ns/1ps
module fbs_swap_ctrl_test;
   localparam int WORDS = 16;
   localparam int AW = $clog2(WORDS);
   localparam logic [31:0] E_FF = 32'hFFFF_FFFF, E_VER = 32'h00FF_FFFF,
                           E_CPY = 32'h0000_FFFF, E_ACT = 32'h0000_00FF;

   logic clk = 1'b0, rst_n = 1'b0, swap_req = 1'b0, append_req = 1'b0, copy_done = 1'b0;
   logic append_grant, copy_start, copy_src, copy_dst, fl_req, fl_blk, active_blk, ready, busy, fatal;
   logic [1:0] fl_op;
   logic [AW-1:0] fl_addr;
   logic [31:0] fl_wdata, fl_rdata = '0;
   logic fl_done = 1'b0;

   always #10 clk = ~clk;

   fbs_swap_ctrl #(.WORDS(WORDS)) uut (.*);

   int tests = 0, fails = 0;
   task automatic chk(input logic ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // flash model
   logic [31:0] mem [2][WORDS];
   int stuck [2];
   int m_lat = 0;
   logic [1:0] m_op; logic m_blk; logic [AW-1:0] m_addr; logic [31:0] m_data;
   always @(posedge clk) begin
      fl_done <= 1'b0;
      if (m_lat != 0) begin
         m_lat <= m_lat - 1;
         if (m_lat == 1) begin
            fl_done <= 1'b1;
            if (m_op == 2'd0) fl_rdata <= mem[m_blk][m_addr];
            else if (m_op == 2'd1) mem[m_blk][m_addr] <= mem[m_blk][m_addr] & m_data;
            else begin
               for (int i = 0; i < WORDS; i++)
                  mem[m_blk][i] <= (i == WORDS - 1 && stuck[m_blk] > 0) ? 32'h0 : E_FF;
               if (stuck[m_blk] > 0) stuck[m_blk] <= stuck[m_blk] - 1;
            end
         end
      end else if (fl_req) begin
         m_op <= fl_op; m_blk <= fl_blk; m_addr <= fl_addr; m_data <= fl_wdata; m_lat <= 3;
      end
   end

   // record enumerator model
   int cp_cnt = 0;
   always @(posedge clk) begin
      copy_done <= 1'b0;
      if (cp_cnt > 0) begin
         cp_cnt <= cp_cnt - 1;
         if (cp_cnt == 1) copy_done <= 1'b1;
      end else if (copy_start) cp_cnt <= 4;
   end

   // scoreboard
   typedef struct { logic [1:0] op; logic blk; logic [31:0] data; string req; } item_t;
   item_t q[$];
   logic exp_src = 1'b0;
   task automatic exp_cmd(input logic [1:0] op, input logic blk, input logic [31:0] d, input string req);
      item_t it;
      it.op = op; it.blk = blk; it.data = d; it.req = req;
      q.push_back(it);
   endtask

   always @(negedge clk) begin
      if (rst_n && fl_req && fl_op != 2'd0) begin
         if (q.size() == 0) chk(1'b0, "R10", "unexpected flash command", {29'd0, fl_blk, fl_op}, 32'h0);
         else begin
            item_t it;
            it = q.pop_front();
            chk(fl_op == it.op, it.req, "command op", {30'd0, fl_op}, {30'd0, it.op});
            chk(fl_blk == it.blk, it.req, "command block", {31'd0, fl_blk}, {31'd0, it.blk});
            if (it.op == 2'd1)
               chk(fl_wdata == it.data && fl_addr == '0, it.req, "status value", fl_wdata, it.data);
         end
      end
      if (rst_n && copy_start) begin
         chk(copy_src == exp_src, "R3", "copy_src", {31'd0, copy_src}, {31'd0, exp_src});
         chk(copy_dst == ~exp_src, "R3", "copy_dst", {31'd0, copy_dst}, {31'd0, ~exp_src});
      end
   end

   task automatic load(input int b, input logic [31:0] st, input int used);
      for (int i = 0; i < WORDS; i++) mem[b][i] = E_FF;
      mem[b][0] = st;
      for (int i = 1; i <= used; i++) mem[b][i] = 32'h0000_1234;
      stuck[b] = 0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(!ready && !fatal && !fl_req, "R9", "reset outputs", {29'd0, ready, fatal, fl_req}, 32'h0);
      rst_n = 1'b1;
   endtask

   task automatic settle();
      do @(negedge clk); while (!((ready && !busy) || fatal));
      repeat (2) @(negedge clk);
      chk(q.size() == 0, "R10", "pending expected commands", q.size(), 32'h0);
   endtask

   task automatic chk_act(input logic a, input string req);
      chk(ready && active_blk == a, req, "active block", {30'd0, ready, active_blk}, {30'd0, 1'b1, a});
   endtask

   task automatic swap_tail(input logic from);
      exp_cmd(2'd1, ~from, E_CPY, "R3"); exp_cmd(2'd1, ~from, E_ACT, "R3");
      exp_cmd(2'd2, from, 0, "R3");      exp_cmd(2'd1, from, E_VER, "R2");
   endtask

   initial begin
      fork
         begin
            // fresh part: both erased
            load(0, E_FF, 0); load(1, E_FF, 0);
            exp_cmd(2'd2, 0, 0, "R4"); exp_cmd(2'd1, 0, E_VER, "R4");
            exp_cmd(2'd2, 1, 0, "R4"); exp_cmd(2'd1, 1, E_VER, "R4");
            exp_cmd(2'd1, 0, E_ACT, "R7");
            do_reset(); settle(); chk_act(1'b0, "R7");
            append_req = 1'b1; @(negedge clk);
            chk(append_grant == 1'b1, "R9", "grant when idle", {31'd0, append_grant}, 32'h1);
            // normal swap
            exp_src = 1'b0; swap_tail(1'b0);
            swap_req = 1'b1; @(negedge clk); swap_req = 1'b0; @(negedge clk);
            chk(busy && !append_grant, "R9", "refuse during swap", {30'd0, busy, append_grant}, 32'h2);
            append_req = 1'b0;
            settle(); chk_act(1'b1, "R3");
            // interrupted during copy
            load(0, E_ACT, 3); load(1, E_CPY, 2);
            exp_cmd(2'd2, 1, 0, "R5"); exp_cmd(2'd1, 1, E_VER, "R5");
            exp_src = 1'b0; swap_tail(1'b0);
            do_reset(); settle(); chk_act(1'b1, "R5");
            // both active, block 1 emptier
            load(0, E_ACT, 6); load(1, E_ACT, 2);
            exp_cmd(2'd2, 0, 0, "R6"); exp_cmd(2'd1, 0, E_VER, "R6");
            do_reset(); settle(); chk_act(1'b1, "R6");
            // both active, tie
            load(0, E_ACT, 0); load(1, E_ACT, 0);
            exp_cmd(2'd2, 1, 0, "R6"); exp_cmd(2'd1, 1, E_VER, "R6");
            do_reset(); settle(); chk_act(1'b0, "R6");
            // garbage status in block 0
            load(0, 32'h1234_5678, 0); load(1, E_ACT, 1);
            exp_cmd(2'd2, 0, 0, "R4"); exp_cmd(2'd1, 0, E_VER, "R4");
            do_reset(); settle(); chk_act(1'b1, "R4");
            // one failed blank check, retry succeeds
            load(0, E_ACT, 1); load(1, E_FF, 0); stuck[1] = 1;
            exp_cmd(2'd2, 1, 0, "R8"); exp_cmd(2'd2, 1, 0, "R8"); exp_cmd(2'd1, 1, E_VER, "R2");
            do_reset(); settle(); chk_act(1'b0, "R8");
            chk(!fatal, "R8", "no fatal after retry", {31'd0, fatal}, 32'h0);
            // two failures: fatal
            load(0, E_ACT, 1); load(1, E_FF, 0); stuck[1] = 2;
            exp_cmd(2'd2, 1, 0, "R8"); exp_cmd(2'd2, 1, 0, "R8");
            do_reset(); settle();
            repeat (60) @(negedge clk);
            chk(fatal && !ready, "R8", "fatal raised", {30'd0, fatal, ready}, 32'h2);
            append_req = 1'b1; @(negedge clk);
            chk(!append_grant, "R9", "no grant when fatal", {31'd0, append_grant}, 32'h0);
            append_req = 1'b0;
         end
         begin
            repeat (100000) @(posedge clk);
            chk(1'b0, "R9", "watchdog expired", 32'h0, 32'h1);
         end
      join_any
      disable fork;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule